// File: doc/BRIEF.md
# Flash Byte Program and Chip Erase Sequencer

This block runs the step-by-step (non-automatic) write algorithms of a byte-wide flash device from the host side. After a start request it walks an address window from a base to a last address. It issues every command write and every read-back as a single bus-master transaction. Between steps it waits a number of clock cycles set by a parameter. When the run ends it reports pass or fail.

In program mode, each byte of the window is written with the byte that the data source returns for that address. The byte is then verified, and the write is repeated until it matches or the per-byte attempt budget runs out. In erase mode, the block first reads the whole window. If any byte is not zero, it programs every byte of the window to 00h. Only then does it erase the chip and verify each address for FFh. A failed address starts a new erase, and verification resumes at that address. The run fails when the budget of erase passes is used up.

The block holds the programming-voltage enable high for as long as a run is active. The flash device, the switch for that supply and the data source all sit outside the block.

Top module: `nvm_seq_top`

## Requirements
- R1: After reset, and while idle, busReq, vppEnable, busy and done are all low.
- R2: In program mode (opErase=0), each attempt on the current byte follows a fixed order. First a write of command 40h. Then a write of srcData to busAddr (srcAddr equals busAddr). Then a write of command C0h. Last, a read of the same address. A read equal to srcData moves on to the next address.
- R3: The gap between a transaction and the next request is held at a minimum. After the program data write it is at least PGM_WAIT cycles. After a C0h or A0h write it is at least VFY_WAIT cycles. After the second 20h write it is at least ERS_WAIT cycles.
- R4: A byte whose read-back mismatches is programmed again. The run fails once a single byte has had PGM_TRIES attempts without a match. The attempt count starts again at zero for each new byte.
- R5: Erase mode (opErase=1) starts by reading every address in the window. If any of those bytes is not 00h, every byte in the window is programmed to 00h, using the R2/R4 loop with 00h as the data. Otherwise no program command is issued.
- R6: An erase pass is two writes of 20h. Verification follows: for each address, a write of A0h at that address, then a read of that address. FFh passes the address. Any other value starts a new erase pass, and verification then resumes at the failing address.
- R7: The run fails when ERS_TRIES erase passes have each ended in a failed verify.
- R8: A successful run ends with a write of command 00h. vppEnable then drops, and done pulses for one cycle with pass=1.
- R9: A failed run pulses done for one cycle with pass=0 and vppEnable low. It issues no further bus transactions.
- R10: vppEnable is high whenever busReq is high.
- R11: While busy is high, start is ignored, whatever the values on opErase, baseAddr and lastAddr.
- R12: Once raised, busReq holds, with busAddr, busWrite and busWdata stable, until the cycle in which busAck is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (sampled when idle) |
| opErase | input | 1 | 0 = program window, 1 = erase chip |
| baseAddr | input | AW | First address of the window |
| lastAddr | input | AW | Last address of the window |
| srcAddr | output | AW | Address presented to the data source |
| srcData | input | 8 | Byte to program at srcAddr |
| busReq | output | 1 | Transaction request |
| busWrite | output | 1 | 1 = write, 0 = read |
| busAddr | output | AW | Transaction address |
| busWdata | output | 8 | Write data or command byte |
| busAck | input | 1 | Transaction accepted / read data valid |
| busRdata | input | 8 | Read data, valid with busAck |
| vppEnable | output | 1 | Programming supply request |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Result, valid with done |

## Verification
The cases that are hardest to reach are the ones that need the flash to misbehave on purpose. One is a partial erase that leaves the upper part of the window at 00h. The other is a single byte that programs only on a chosen attempt. The bench's flash model takes per-address attempt thresholds and an erase split point, so a run can be steered to succeed exactly on the last permitted attempt or to fail one attempt later. Its first A0h address after each re-erase shows whether verification resumed at the right place. Running out the erase budget takes a thousand full passes, so the wait parameters are kept small enough for both boundary runs to fit.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;

  localparam logic [7:0] CMD_READ    = 8'h00;
  localparam logic [7:0] CMD_PGM     = 8'h40;
  localparam logic [7:0] CMD_PGM_VFY = 8'hC0;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_ERS_VFY = 8'hA0;

  typedef enum logic [1:0] {BUS_IDLE, BUS_CMD, BUS_DATA, BUS_READ} busKind_t;
  typedef enum logic [1:0] {WAIT_PGM, WAIT_VFY, WAIT_ERS} waitSel_t;

  // control -> datapath
  typedef struct packed {
    busKind_t   busKind;
    logic [7:0] cmdCode;
    logic       latchReq;
    logic       loadBase;
    logic       incAddr;
    logic       clrTry;
    logic       incTry;
    logic       startWait;
    waitSel_t   waitSel;
    logic       setDirty;
  } ctlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic atLast;
    logic waitDone;
    logic readMatch;
    logic readErased;
    logic readZero;
    logic pgmTryLast;
    logic ersTryLast;
    logic dirty;
    logic eraseMode;
  } dpStatus_t;

endpackage

// File: rtl/nvm_seq_dp.sv
module nvm_seq_dp
  import nvm_seq_pkg::*;
#(
  parameter int AW        = 17,
  parameter int PGM_WAIT  = 2000,
  parameter int VFY_WAIT  = 1200,
  parameter int ERS_WAIT  = 1900000,
  parameter int PGM_TRIES = 25,
  parameter int ERS_TRIES = 1000
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobe_t    stb,
  input  logic          opErase,
  input  logic [AW-1:0] baseAddr,
  input  logic [AW-1:0] lastAddr,
  output logic [AW-1:0] srcAddr,
  input  logic [7:0]    srcData,
  output logic          busReq,
  output logic          busWrite,
  output logic [AW-1:0] busAddr,
  output logic [7:0]    busWdata,
  input  logic [7:0]    busRdata,
  output dpStatus_t     sts
);

  localparam int WAIT_MAX0 = (PGM_WAIT > VFY_WAIT) ? PGM_WAIT : VFY_WAIT;
  localparam int WAIT_MAX  = (WAIT_MAX0 > ERS_WAIT) ? WAIT_MAX0 : ERS_WAIT;
  localparam int WAIT_W    = $clog2(WAIT_MAX + 1);
  localparam int TRY_MAX   = (PGM_TRIES > ERS_TRIES) ? PGM_TRIES : ERS_TRIES;
  localparam int TRY_W     = $clog2(TRY_MAX + 1);
  localparam logic [WAIT_W-1:0] PGM_LOAD = WAIT_W'(PGM_WAIT - 1);
  localparam logic [WAIT_W-1:0] VFY_LOAD = WAIT_W'(VFY_WAIT - 1);
  localparam logic [WAIT_W-1:0] ERS_LOAD = WAIT_W'(ERS_WAIT - 1);

  logic [AW-1:0]     addrQ, baseQ, lastQ;
  logic              modeQ, dirtyQ;
  logic [TRY_W-1:0]  tryQ;
  logic [WAIT_W-1:0] waitQ, waitLoad;
  logic [7:0]        expData;

  always_comb begin
    unique case (stb.waitSel)
      WAIT_PGM: waitLoad = PGM_LOAD;
      WAIT_VFY: waitLoad = VFY_LOAD;
      default:  waitLoad = ERS_LOAD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      baseQ  <= '0;
      lastQ  <= '0;
      modeQ  <= 1'b0;
      dirtyQ <= 1'b0;
      tryQ   <= '0;
      waitQ  <= '0;
    end else begin
      if (stb.latchReq) begin
        baseQ <= baseAddr;
        lastQ <= lastAddr;
        addrQ <= baseAddr;
        modeQ <= opErase;
      end else if (stb.loadBase) begin
        addrQ <= baseQ;
      end else if (stb.incAddr) begin
        addrQ <= addrQ + AW'(1);
      end

      if (stb.latchReq)      dirtyQ <= 1'b0;
      else if (stb.setDirty) dirtyQ <= 1'b1;

      if (stb.latchReq || stb.clrTry) tryQ <= '0;
      else if (stb.incTry)            tryQ <= tryQ + TRY_W'(1);

      if (stb.startWait)      waitQ <= waitLoad;
      else if (waitQ != '0)   waitQ <= waitQ - WAIT_W'(1);
    end
  end

  // in erase mode the program loop is only used to preprogram to zero
  assign expData  = modeQ ? 8'h00 : srcData;
  assign srcAddr  = addrQ;
  assign busAddr  = addrQ;
  assign busReq   = (stb.busKind != BUS_IDLE);
  assign busWrite = (stb.busKind != BUS_READ);
  assign busWdata = (stb.busKind == BUS_DATA) ? expData : stb.cmdCode;

  assign sts.atLast     = (addrQ == lastQ);
  assign sts.waitDone   = (waitQ == '0);
  assign sts.readMatch  = (busRdata == expData);
  assign sts.readErased = (busRdata == 8'hFF);
  assign sts.readZero   = (busRdata == 8'h00);
  assign sts.pgmTryLast = (tryQ == TRY_W'(PGM_TRIES - 1));
  assign sts.ersTryLast = (tryQ == TRY_W'(ERS_TRIES - 1));
  assign sts.dirty      = dirtyQ;
  assign sts.eraseMode  = modeQ;

endmodule

// File: rtl/nvm_seq_ctl.sv
module nvm_seq_ctl
  import nvm_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       opErase,
  input  logic       busAck,
  input  dpStatus_t  sts,
  output ctlStrobe_t stb,
  output logic       busy,
  output logic       done,
  output logic       pass,
  output logic       vppEnable
);

  typedef enum logic [4:0] {
    S_IDLE, S_SCAN,
    S_PG_CMD, S_PG_DATA, S_PG_PWAIT, S_PG_VCMD, S_PG_VWAIT, S_PG_READ,
    S_ER_CMD1, S_ER_CMD2, S_ER_WAIT, S_EV_CMD, S_EV_WAIT, S_EV_READ,
    S_FIN, S_OK, S_FAIL
  } state_t;

  state_t stQ, stNxt;

  always_ff @(posedge clk) begin
    if (!rstN) stQ <= S_IDLE;
    else       stQ <= stNxt;
  end

  always_comb begin
    stb   = '0;
    stNxt = stQ;
    unique case (stQ)
      S_IDLE: if (start) begin
        stb.latchReq = 1'b1;
        stNxt = opErase ? S_SCAN : S_PG_CMD;
      end
      S_SCAN: begin
        stb.busKind = BUS_READ;
        if (busAck) begin
          stb.setDirty = !sts.readZero;
          if (sts.atLast) begin
            stb.loadBase = 1'b1;
            stNxt = (sts.dirty || !sts.readZero) ? S_PG_CMD : S_ER_CMD1;
          end else begin
            stb.incAddr = 1'b1;
          end
        end
      end
      S_PG_CMD: begin
        stb.busKind = BUS_CMD;
        stb.cmdCode = CMD_PGM;
        if (busAck) stNxt = S_PG_DATA;
      end
      S_PG_DATA: begin
        stb.busKind = BUS_DATA;
        stb.waitSel = WAIT_PGM;
        if (busAck) begin
          stb.startWait = 1'b1;
          stNxt = S_PG_PWAIT;
        end
      end
      S_PG_PWAIT: if (sts.waitDone) stNxt = S_PG_VCMD;
      S_PG_VCMD: begin
        stb.busKind = BUS_CMD;
        stb.cmdCode = CMD_PGM_VFY;
        stb.waitSel = WAIT_VFY;
        if (busAck) begin
          stb.startWait = 1'b1;
          stNxt = S_PG_VWAIT;
        end
      end
      S_PG_VWAIT: if (sts.waitDone) stNxt = S_PG_READ;
      S_PG_READ: begin
        stb.busKind = BUS_READ;
        if (busAck) begin
          if (sts.readMatch) begin
            stb.clrTry = 1'b1;
            if (!sts.atLast) begin
              stb.incAddr = 1'b1;
              stNxt = S_PG_CMD;
            end else if (sts.eraseMode) begin
              stb.loadBase = 1'b1;
              stNxt = S_ER_CMD1;
            end else begin
              stNxt = S_FIN;
            end
          end else if (sts.pgmTryLast) begin
            stNxt = S_FAIL;
          end else begin
            stb.incTry = 1'b1;
            stNxt = S_PG_CMD;
          end
        end
      end
      S_ER_CMD1: begin
        stb.busKind = BUS_CMD;
        stb.cmdCode = CMD_ERASE;
        if (busAck) stNxt = S_ER_CMD2;
      end
      S_ER_CMD2: begin
        stb.busKind = BUS_CMD;
        stb.cmdCode = CMD_ERASE;
        stb.waitSel = WAIT_ERS;
        if (busAck) begin
          stb.startWait = 1'b1;
          stNxt = S_ER_WAIT;
        end
      end
      S_ER_WAIT: if (sts.waitDone) stNxt = S_EV_CMD;
      S_EV_CMD: begin
        stb.busKind = BUS_CMD;
        stb.cmdCode = CMD_ERS_VFY;
        stb.waitSel = WAIT_VFY;
        if (busAck) begin
          stb.startWait = 1'b1;
          stNxt = S_EV_WAIT;
        end
      end
      S_EV_WAIT: if (sts.waitDone) stNxt = S_EV_READ;
      S_EV_READ: begin
        stb.busKind = BUS_READ;
        if (busAck) begin
          if (sts.readErased) begin
            if (sts.atLast) stNxt = S_FIN;
            else begin
              stb.incAddr = 1'b1;
              stNxt = S_EV_CMD;
            end
          end else if (sts.ersTryLast) begin
            stNxt = S_FAIL;
          end else begin
            stb.incTry = 1'b1;   // erase again, address kept
            stNxt = S_ER_CMD1;
          end
        end
      end
      S_FIN: begin
        stb.busKind = BUS_CMD;
        stb.cmdCode = CMD_READ;
        if (busAck) stNxt = S_OK;
      end
      S_OK:    stNxt = S_IDLE;
      S_FAIL:  stNxt = S_IDLE;
      default: stNxt = S_IDLE;
    endcase
  end

  assign busy      = !(stQ inside {S_IDLE, S_OK, S_FAIL});
  assign vppEnable = busy;
  assign done      = (stQ == S_OK) || (stQ == S_FAIL);
  assign pass      = (stQ == S_OK);

endmodule

// File: rtl/nvm_seq_top.sv
module nvm_seq_top
  import nvm_seq_pkg::*;
#(
  parameter int AW        = 17,
  parameter int PGM_WAIT  = 2000,
  parameter int VFY_WAIT  = 1200,
  parameter int ERS_WAIT  = 1900000,
  parameter int PGM_TRIES = 25,
  parameter int ERS_TRIES = 1000
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          opErase,
  input  logic [AW-1:0] baseAddr,
  input  logic [AW-1:0] lastAddr,
  output logic [AW-1:0] srcAddr,
  input  logic [7:0]    srcData,
  output logic          busReq,
  output logic          busWrite,
  output logic [AW-1:0] busAddr,
  output logic [7:0]    busWdata,
  input  logic          busAck,
  input  logic [7:0]    busRdata,
  output logic          vppEnable,
  output logic          busy,
  output logic          done,
  output logic          pass
);

  ctlStrobe_t stb;
  dpStatus_t  sts;

  nvm_seq_ctl u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .opErase(opErase),
    .busAck(busAck), .sts(sts), .stb(stb), .busy(busy),
    .done(done), .pass(pass), .vppEnable(vppEnable)
  );

  nvm_seq_dp #(
    .AW(AW), .PGM_WAIT(PGM_WAIT), .VFY_WAIT(VFY_WAIT), .ERS_WAIT(ERS_WAIT),
    .PGM_TRIES(PGM_TRIES), .ERS_TRIES(ERS_TRIES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .opErase(opErase),
    .baseAddr(baseAddr), .lastAddr(lastAddr), .srcAddr(srcAddr),
    .srcData(srcData), .busReq(busReq), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .sts(sts)
  );

endmodule

// File: rtl/nvm_seq_chk.sv
module nvm_seq_chk #(
  parameter int AW = 17
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic          busReq,
  input logic          busWrite,
  input logic [AW-1:0] busAddr,
  input logic [7:0]    busWdata,
  input logic          busAck,
  input logic          vppEnable,
  input logic          busy,
  input logic          done
);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> busReq && $stable(busAddr) && $stable(busWrite) && $stable(busWdata)); // R12

  AST_VPP_WITH_REQ: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> vppEnable); // R10

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !vppEnable && !busReq && !busy); // R9

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    busy && start && !done |=> busy || done); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy && !start |=> !busReq); // R1

endmodule

bind nvm_seq_top nvm_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busReq(busReq), .busWrite(busWrite),
  .busAddr(busAddr), .busWdata(busWdata), .busAck(busAck),
  .vppEnable(vppEnable), .busy(busy), .done(done)
);

// File: tb/nvm_seq_top_tb.sv
module nvm_seq_top_tb;

  localparam int AW = 4;
  localparam int NADDR = 16;
  localparam int PGM_WAIT = 4;
  localparam int VFY_WAIT = 3;
  localparam int ERS_WAIT = 20;
  localparam int PGM_TRIES = 25;
  localparam int ERS_TRIES = 1000;

  typedef struct packed {
    logic        isErase;
    logic [3:0]  base;
    logic [3:0]  last;
    logic [3:0]  hardAddr;
    logic [7:0]  hardNeed;
    logic [10:0] eraseNeed;
    logic [3:0]  split;
    logic        initZero;
    logic        expPass;
    logic [15:0] expPgm;
    logic [10:0] expErase;
    logic [10:0] expVerify;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 4'd0, 4'd15, 4'd0, 8'd1,  11'd1,    4'd0, 1'b0, 1'b1, 16'd16, 11'd0,    11'd0},
    '{1'b0, 4'd3, 4'd6,  4'd5, 8'd4,  11'd1,    4'd0, 1'b0, 1'b1, 16'd7,  11'd0,    11'd0},
    '{1'b0, 4'd2, 4'd4,  4'd3, 8'd25, 11'd1,    4'd0, 1'b0, 1'b1, 16'd27, 11'd0,    11'd0},
    '{1'b0, 4'd2, 4'd4,  4'd3, 8'd26, 11'd1,    4'd0, 1'b0, 1'b0, 16'd26, 11'd0,    11'd0},
    '{1'b1, 4'd0, 4'd15, 4'd0, 8'd1,  11'd1,    4'd0, 1'b1, 1'b1, 16'd0,  11'd1,    11'd16},
    '{1'b1, 4'd0, 4'd15, 4'd7, 8'd3,  11'd1,    4'd0, 1'b0, 1'b1, 16'd18, 11'd1,    11'd16},
    '{1'b1, 4'd0, 4'd15, 4'd0, 8'd1,  11'd3,    4'd6, 1'b1, 1'b1, 16'd0,  11'd3,    11'd18},
    '{1'b1, 4'd0, 4'd15, 4'd0, 8'd1,  11'd1000, 4'd6, 1'b1, 1'b1, 16'd0,  11'd1000, 11'd1015},
    '{1'b1, 4'd0, 4'd15, 4'd0, 8'd1,  11'd1001, 4'd6, 1'b1, 1'b0, 16'd0,  11'd1000, 11'd1006}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          opErase = 1'b0;
  logic [AW-1:0] baseAddr = '0;
  logic [AW-1:0] lastAddr = '0;
  logic [AW-1:0] srcAddr;
  logic [7:0]    srcData;
  logic          busReq, busWrite;
  logic [AW-1:0] busAddr;
  logic [7:0]    busWdata;
  logic          busAck = 1'b0;
  logic [7:0]    busRdata = '0;
  logic          vppEnable, busy, done, pass;

  always #2.5 clk = ~clk;

  assign srcData = {srcAddr, ~srcAddr};

  nvm_seq_top #(
    .AW(AW), .PGM_WAIT(PGM_WAIT), .VFY_WAIT(VFY_WAIT), .ERS_WAIT(ERS_WAIT),
    .PGM_TRIES(PGM_TRIES), .ERS_TRIES(ERS_TRIES)
  ) u_dut (.*);

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // flash model state
  logic [7:0] mem [NADDR];
  int  att [NADDR];
  int  hardAddr, hardNeed, eraseNeed, splitAt;
  int  pgmAttempts, erasePasses, verifies, xfers, timingViol;
  int  cyc = 0, lastAckCyc = 0, needGap = 0;
  int  firstA0;
  bit  pgmPending, prev20, afterErase;
  logic [7:0] lastCmd;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic serve();
    int a;
    a = int'(busAddr);
    if (busWrite) begin
      if (pgmPending) begin
        pgmPending = 1'b0;
        pgmAttempts++;
        att[a]++;
        if (att[a] >= ((a == hardAddr) ? hardNeed : 1)) mem[a] = mem[a] & busWdata;
        needGap = PGM_WAIT;
      end else begin
        lastCmd = busWdata;
        needGap = 0;
        if (busWdata != 8'h20) prev20 = 1'b0;
        case (busWdata)
          8'h40: pgmPending = 1'b1;
          8'hC0: needGap = VFY_WAIT;
          8'hA0: begin
            verifies++;
            needGap = VFY_WAIT;
            if (afterErase) begin firstA0 = a; afterErase = 1'b0; end
          end
          8'h20: begin
            if (prev20) begin
              prev20 = 1'b0;
              erasePasses++;
              for (int i = 0; i < NADDR; i++)
                if (erasePasses >= eraseNeed || i < splitAt) mem[i] = 8'hFF;
              needGap = ERS_WAIT;
              afterErase = 1'b1;
            end else prev20 = 1'b1;
          end
          default: ;
        endcase
      end
    end else begin
      busRdata = mem[a];
      needGap = 0;
    end
  endtask

  // bus responder and flash model
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (busAck) begin
        busAck = 1'b0;
        lastAckCyc = cyc;
      end else if (rstN && busReq) begin
        if (cyc - lastAckCyc < needGap) timingViol++;
        serve();
        xfers++;
        busAck = 1'b1;
      end
    end
  end

  task automatic prepare(input vec_t v);
    for (int i = 0; i < NADDR; i++) begin
      mem[i] = !v.isErase ? 8'hFF : (v.initZero ? 8'h00 : (8'h80 | 8'(i)));
      att[i] = 0;
    end
    hardAddr = int'(v.hardAddr);
    hardNeed = int'(v.hardNeed);
    eraseNeed = int'(v.eraseNeed);
    splitAt = int'(v.split);
    pgmAttempts = 0; erasePasses = 0; verifies = 0; timingViol = 0;
    pgmPending = 1'b0; prev20 = 1'b0; afterErase = 1'b0;
    firstA0 = -1; lastCmd = 8'h55;
  endtask

  task automatic launch(input vec_t v);
    @(negedge clk);
    opErase = v.isErase; baseAddr = v.base; lastAddr = v.last; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish(input vec_t v, input int idx);
    int x0;
    while (!done) @(negedge clk);
    chk(pass == v.expPass, $sformatf("R4/R7 pass vec%0d", idx), int'(pass), int'(v.expPass));
    chk(!vppEnable, $sformatf("R8/R9 vpp at done vec%0d", idx), int'(vppEnable), 0);
    chk(pgmAttempts == int'(v.expPgm), $sformatf("R4/R5 program attempts vec%0d", idx),
        pgmAttempts, int'(v.expPgm));
    chk(erasePasses == int'(v.expErase), $sformatf("R6/R7 erase passes vec%0d", idx),
        erasePasses, int'(v.expErase));
    chk(verifies == int'(v.expVerify), $sformatf("R6 verify writes vec%0d", idx),
        verifies, int'(v.expVerify));
    chk(timingViol == 0, $sformatf("R3 wait gaps vec%0d", idx), timingViol, 0);
    if (v.expPass) chk(lastCmd == 8'h00, $sformatf("R8 final command vec%0d", idx),
                       int'(lastCmd), 0);
    if (v.expPass && !v.isErase)
      for (int a = int'(v.base); a <= int'(v.last); a++)
        chk(mem[a] == {4'(a), ~4'(a)}, $sformatf("R2 byte %0d vec%0d", a, idx),
            int'(mem[a]), int'({4'(a), ~4'(a)}));
    if (v.expPass && v.isErase)
      for (int a = 0; a < NADDR; a++)
        chk(mem[a] == 8'hFF, $sformatf("R6 erased byte %0d vec%0d", a, idx), int'(mem[a]), 255);
    if (v.expErase > 1)
      chk(firstA0 == int'(v.split), $sformatf("R6 resume address vec%0d", idx),
          firstA0, int'(v.split));
    x0 = xfers;
    repeat (4) @(negedge clk);
    chk(xfers == x0 && !busReq && !busy, $sformatf("R9 quiet after done vec%0d", idx),
        xfers - x0, 0);
  endtask

  initial begin
    repeat (200000 - 5000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    vec_t d;
    repeat (3) @(negedge clk);
    chk(!busReq && !vppEnable && !done && !busy, "R1 state in reset",
        int'({busReq, vppEnable, done, busy}), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busReq && !vppEnable && !done && !busy, "R1 idle after reset",
        int'({busReq, vppEnable, done, busy}), 0);

    for (int i = 0; i < NVEC; i++) begin
      prepare(VECS[i]);
      launch(VECS[i]);
      finish(VECS[i], i);
    end

    // R11: a second start during a program run must not redirect it
    d = '{1'b0, 4'd0, 4'd3, 4'd0, 8'd1, 11'd1, 4'd0, 1'b0, 1'b1, 16'd4, 11'd0, 11'd0};
    prepare(d);
    launch(d);
    repeat (8) @(negedge clk);
    opErase = 1'b1; baseAddr = 4'd8; lastAddr = 4'd9; start = 1'b1;
    @(negedge clk);
    start = 1'b0; opErase = 1'b0;
    finish(d, 99);
    chk(mem[8] == 8'hFF && mem[9] == 8'hFF, "R11 window untouched by ignored start",
        int'(mem[8]), 255);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule